// File: doc/BRIEF.md
# Gated 16-bit Timer/Counter with Prescaler

This block is a 16-bit up-counter held as a high byte and a low byte. It can count in three ways. As a timer, it advances on an internal instruction-cycle enable pulse. As a synchronised counter, it counts rising edges of an external input after that input passes through a two-flop synchroniser. As an unsynchronised counter, it counts the same edges with the synchroniser bypassed. In every mode, a hidden 3-bit prescaler divides the selected source by 1, 2, 4 or 8 before it reaches the counter. An optional gate input can stall counting.

Software loads either counter byte with a byte-wide write, and any such write also empties the prescaler. When the count wraps from FFFFh to 0000h, a sticky overflow flag is set. The interrupt request is this flag qualified by three enable levels: timer, peripheral and global. External-edge counting stays disarmed after enable until the input has been seen low. This keeps a high level at enable from counting as an edge.

Top module: `gtmr16`

## Requirements
- R1: After reset the count is 0000h, the overflow flag is 0 and the interrupt request is 0.
- R2: In timer mode (ctl bit 1 = 0) with run (ctl bit 0) set and prescale 00, the count rises by exactly one at each clock edge where tick_en is 1, and holds otherwise.
- R3: The prescale select at ctl bits 5:4 divides the source by 1, 2, 4 or 8 for encodings 00, 01, 10 and 11. After a counter write, the count shows floor(n / divisor) for n source pulses.
- R4: A wr_lo or wr_hi pulse loads wr_data into the low or high byte at the next edge and leaves the other byte unchanged. Either write also clears the prescaler.
- R5: A write in the same cycle as an increment wins. The written byte is loaded, the increment is dropped, and a wrap in that cycle does not set the flag.
- R6: An increment from FFFFh gives 0000h and sets the overflow flag. The flag stays set until a flag_clr pulse. A wrap in the same cycle as flag_clr leaves the flag set.
- R7: irq_o is 1 exactly when the flag, ie_tmr, ie_per and ie_glb are all 1.
- R8: With gate enable (ctl bit 3) set, no increments occur while gate_in is 0. With gate enable clear, gate_in has no effect.
- R9: While run is 0, the count and the prescaler both hold their values, and counting resumes from the held prescaler state.
- R10: In synchronised counter mode (ctl bit 1 = 1, bit 2 = 0), each rising edge of ext_clk raises the count on the third clock edge after the change. tick_en is ignored in this mode.
- R11: In unsynchronised counter mode (ctl bits 2:1 = 11), a rising edge of ext_clk raises the count at the first clock edge after the change.
- R12: After run goes to 1 in counter mode, a rising edge counts only if ext_clk was seen low while running. An input that is high at enable, or that rises in the enabling cycle, does not count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ctl | input | 8 | Control: bit0 run, bit1 external source, bit2 bypass synchroniser, bit3 gate enable, bits5:4 prescale, bits7:6 unused |
| tick_en | input | 1 | Instruction-cycle enable pulse for timer mode |
| ext_clk | input | 1 | External count input |
| gate_in | input | 1 | Gate; counting allowed while 1 when gating is enabled |
| wr_lo | input | 1 | Load low counter byte |
| wr_hi | input | 1 | Load high counter byte |
| wr_data | input | 8 | Byte to load |
| flag_clr | input | 1 | Clear the overflow flag |
| ie_tmr | input | 1 | Timer interrupt enable |
| ie_per | input | 1 | Peripheral interrupt enable |
| ie_glb | input | 1 | Global interrupt enable |
| cnt_o | output | 16 | Current count {high, low} |
| flag_o | output | 1 | Sticky overflow flag |
| irq_o | output | 1 | Qualified interrupt request |

## Verification
The bench sweeps every prescale setting against 0 to 17 source pulses, each after a fresh write. A prescaler off by one count, or one not emptied by a write, gives a wrong floor. The bench also drives a write in the same cycle as an increment, and in the same cycle as a wrap. A design with the priority reversed would show the written value plus one, or a spurious flag. The bench raises ext_clk in the enabling cycle and also holds it high at enable. A design that arms too early counts one extra edge. Separate latency checks in the two counter modes catch a missing or extra synchroniser stage. A hold test with run low and a part-filled prescaler catches a prescaler that is cleared instead of held.

// File: rtl/gtmr_pkg.sv
package gtmr_pkg;
  localparam int BYTE_W = 8;
  localparam int PS_W   = 2;

  typedef struct packed {
    logic [1:0]      rsv;
    logic [PS_W-1:0] ps;
    logic            gate_en;
    logic            nosync;
    logic            ext_src;
    logic            run;
  } ctl_t;
endpackage

// File: rtl/gtmr_edge.sv
module gtmr_edge #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  input  logic nosync,
  input  logic ext_i,
  output logic rise_o
);
  logic [SYNC_STAGES-1:0] sq;
  logic cur, prev_q, armed_q, armed_d;

  generate
    if (SYNC_STAGES > 1) begin : g_chain
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sq <= '0;
        else        sq <= {sq[SYNC_STAGES-2:0], ext_i};
      end
    end else begin : g_one
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sq <= '0;
        else        sq <= ext_i;
      end
    end
  endgenerate

  always_comb begin
    cur     = nosync ? ext_i : sq[SYNC_STAGES-1];
    armed_d = run & (armed_q | ~cur);
    rise_o  = run & armed_q & cur & ~prev_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev_q  <= 1'b0;
      armed_q <= 1'b0;
    end else begin
      prev_q  <= cur;
      armed_q <= armed_d;
    end
  end
endmodule

// File: rtl/gtmr_presc.sv
module gtmr_presc #(
  parameter int PS_W = 2
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            run,
  input  logic            clr,
  input  logic            pulse_i,
  input  logic [PS_W-1:0] sel,
  output logic            inc_o
);
  localparam int PC_W = (1 << PS_W) - 1;

  logic [PC_W-1:0] pcnt_q, pcnt_d, lim;
  logic            hit, pcnt_en;

  always_comb begin
    for (int i = 0; i < PC_W; i++) lim[i] = (i < int'(sel));
    hit     = pulse_i & (pcnt_q >= lim);
    inc_o   = hit;
    pcnt_en = clr | (run & pulse_i);
    if (clr)      pcnt_d = '0;
    else if (hit) pcnt_d = '0;
    else          pcnt_d = pcnt_q + PC_W'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       pcnt_q <= '0;
    else if (pcnt_en) pcnt_q <= pcnt_d;
  end
endmodule

// File: rtl/gtmr_core.sv
module gtmr_core #(
  parameter int BYTE_W = 8
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                wr_lo,
  input  logic                wr_hi,
  input  logic [BYTE_W-1:0]   wr_data,
  input  logic                inc,
  input  logic                flag_clr,
  output logic [2*BYTE_W-1:0] cnt_o,
  output logic                flag_o
);
  localparam int CNT_W = 2 * BYTE_W;

  logic [BYTE_W-1:0] hi_q, lo_q, hi_d, lo_d;
  logic [CNT_W-1:0]  sum;
  logic              any_wr, wrap, flag_q, flag_d, cnt_en;

  always_comb begin
    any_wr = wr_lo | wr_hi;
    sum    = {hi_q, lo_q} + CNT_W'(1);
    wrap   = inc & ~any_wr & (&{hi_q, lo_q});
    cnt_en = any_wr | inc;
    hi_d   = hi_q;
    lo_d   = lo_q;
    if (any_wr) begin
      if (wr_lo) lo_d = wr_data;
      if (wr_hi) hi_d = wr_data;
    end else begin
      {hi_d, lo_d} = sum;
    end
    flag_d = wrap | (flag_q & ~flag_clr);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hi_q <= '0;
      lo_q <= '0;
    end else if (cnt_en) begin
      hi_q <= hi_d;
      lo_q <= lo_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) flag_q <= 1'b0;
    else        flag_q <= flag_d;
  end

  assign cnt_o  = {hi_q, lo_q};
  assign flag_o = flag_q;
endmodule

// File: rtl/gtmr16.sv
module gtmr16
  import gtmr_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [7:0]          ctl,
  input  logic                tick_en,
  input  logic                ext_clk,
  input  logic                gate_in,
  input  logic                wr_lo,
  input  logic                wr_hi,
  input  logic [BYTE_W-1:0]   wr_data,
  input  logic                flag_clr,
  input  logic                ie_tmr,
  input  logic                ie_per,
  input  logic                ie_glb,
  output logic [2*BYTE_W-1:0] cnt_o,
  output logic                flag_o,
  output logic                irq_o
);
  ctl_t c;
  logic rise, src, gate_ok, pulse, inc;

  assign c = ctl_t'(ctl);

  gtmr_edge #(.SYNC_STAGES(SYNC_STAGES)) u_edge (
    .clk(clk), .rst_n(rst_n), .run(c.run), .nosync(c.nosync),
    .ext_i(ext_clk), .rise_o(rise)
  );

  always_comb begin
    src     = c.ext_src ? rise : tick_en;
    gate_ok = ~c.gate_en | gate_in;
    pulse   = c.run & gate_ok & src;
  end

  gtmr_presc #(.PS_W(PS_W)) u_presc (
    .clk(clk), .rst_n(rst_n), .run(c.run), .clr(wr_lo | wr_hi),
    .pulse_i(pulse), .sel(c.ps), .inc_o(inc)
  );

  gtmr_core #(.BYTE_W(BYTE_W)) u_core (
    .clk(clk), .rst_n(rst_n), .wr_lo(wr_lo), .wr_hi(wr_hi),
    .wr_data(wr_data), .inc(inc), .flag_clr(flag_clr),
    .cnt_o(cnt_o), .flag_o(flag_o)
  );

  assign irq_o = flag_o & ie_tmr & ie_per & ie_glb;
endmodule

// File: rtl/gtmr16_chk.sv
module gtmr16_chk (
  input logic        clk,
  input logic        rst_n,
  input logic [7:0]  ctl,
  input logic        gate_in,
  input logic        wr_lo,
  input logic        wr_hi,
  input logic [7:0]  wr_data,
  input logic        flag_clr,
  input logic [15:0] cnt_o,
  input logic        flag_o,
  input logic        irq_o
);
  assert_step_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (!wr_lo && !wr_hi) |=> (cnt_o == $past(cnt_o) || cnt_o == $past(cnt_o) + 16'd1));

  assert_lo_load_R4: assert property (@(posedge clk) disable iff (!rst_n)
    wr_lo |=> cnt_o[7:0] == $past(wr_data));

  assert_hi_load_R4: assert property (@(posedge clk) disable iff (!rst_n)
    wr_hi |=> cnt_o[15:8] == $past(wr_data));

  assert_wr_noflag_R5: assert property (@(posedge clk) disable iff (!rst_n)
    ((wr_lo || wr_hi) && !flag_o) |=> !flag_o);

  assert_wrap_zero_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(flag_o) |-> cnt_o == 16'h0000);

  assert_flag_sticky_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (flag_o && !flag_clr) |=> flag_o);

  assert_irq_needs_flag_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !flag_o |-> !irq_o);

  assert_gate_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (ctl[0] && ctl[3] && !gate_in && !wr_lo && !wr_hi) |=> $stable(cnt_o));

  assert_off_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (!ctl[0] && !wr_lo && !wr_hi) |=> $stable(cnt_o));
endmodule

bind gtmr16 gtmr16_chk u_chk (
  .clk(clk), .rst_n(rst_n), .ctl(ctl), .gate_in(gate_in),
  .wr_lo(wr_lo), .wr_hi(wr_hi), .wr_data(wr_data), .flag_clr(flag_clr),
  .cnt_o(cnt_o), .flag_o(flag_o), .irq_o(irq_o)
);

// File: tb/sim_gtmr16.sv
`timescale 1ns/1ps
module sim_gtmr16;
  logic clk, rst_n, tick_en, ext_clk, gate_in, wr_lo, wr_hi, flag_clr;
  logic ie_tmr, ie_per, ie_glb;
  logic [7:0]  ctl, wr_data;
  logic [15:0] cnt_o;
  logic        flag_o, irq_o;
  int checks = 0;
  int errors = 0;

  localparam logic [7:0] RUN = 8'h01, EXT = 8'h02, NOS = 8'h04, GATE = 8'h08;

  gtmr16 u0 (.*);

  initial clk = 1'b0;
  always #2 clk = ~clk;

  task automatic chk(string req, logic [15:0] act, logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic cyc(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr16(logic [15:0] v);
    tick_en = 1'b0;
    wr_lo = 1'b1; wr_data = v[7:0];  cyc(1);
    wr_lo = 1'b0; wr_hi = 1'b1; wr_data = v[15:8]; cyc(1);
    wr_hi = 1'b0;
  endtask

  task automatic ticks(int n);
    for (int i = 0; i < n; i++) begin
      tick_en = 1'b1; cyc(1);
    end
    tick_en = 1'b0;
  endtask

  task automatic pulse_ext();
    ext_clk = 1'b0; cyc(3);
    ext_clk = 1'b1; cyc(3);
  endtask

  initial begin
    #800000;
    checks++; errors++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    rst_n = 0; ctl = 0; tick_en = 0; ext_clk = 0; gate_in = 0;
    wr_lo = 0; wr_hi = 0; wr_data = 0; flag_clr = 0;
    ie_tmr = 1; ie_per = 1; ie_glb = 1;
    cyc(3); rst_n = 1; cyc(1);
    chk("R1 count", cnt_o, 16'h0);
    chk("R1 flag", {15'd0, flag_o}, 16'h0);
    chk("R1 irq", {15'd0, irq_o}, 16'h0);

    // R3 sweep: every prescale against 0..17 pulses
    for (int p = 0; p < 4; p++) begin
      for (int n = 0; n < 18; n++) begin
        ctl = RUN | 8'(p << 4);
        wr16(16'h0);
        ticks(n);
        chk($sformatf("R3 ps=%0d n=%0d", p, n), cnt_o, 16'(n >> p));
      end
    end

    // R2 sparse ticks
    ctl = RUN; wr16(16'h0);
    for (int i = 0; i < 10; i++) begin
      tick_en = i[0]; cyc(1);
    end
    tick_en = 1'b0;
    chk("R2 alternating ticks", cnt_o, 16'd5);

    // R4 loads and prescaler clear
    wr16(16'hBEEF);
    chk("R4 both bytes", cnt_o, 16'hBEEF);
    wr_hi = 1; wr_data = 8'h12; cyc(1); wr_hi = 0;
    chk("R4 high only", cnt_o, 16'h12EF);
    ctl = RUN | 8'h30; wr16(16'h00A0);
    ticks(5);
    wr16(16'h00A0);
    ticks(7);
    chk("R4 prescaler cleared (7)", cnt_o, 16'h00A0);
    ticks(1);
    chk("R4 prescaler cleared (8)", cnt_o, 16'h00A1);

    // R5 write priority
    ctl = RUN; wr16(16'h1234);
    tick_en = 1; wr_lo = 1; wr_data = 8'h55; cyc(1);
    tick_en = 0; wr_lo = 0;
    chk("R5 write beats inc", cnt_o, 16'h1255);
    wr16(16'hFFFF);
    tick_en = 1; wr_hi = 1; wr_data = 8'hFF; cyc(1);
    tick_en = 0; wr_hi = 0;
    chk("R5 count held", cnt_o, 16'hFFFF);
    chk("R5 no flag", {15'd0, flag_o}, 16'h0);

    // R6 wrap and flag
    ticks(1);
    chk("R6 wrap count", cnt_o, 16'h0000);
    chk("R6 flag set", {15'd0, flag_o}, 16'h1);
    cyc(3);
    chk("R6 flag sticky", {15'd0, flag_o}, 16'h1);
    flag_clr = 1; cyc(1); flag_clr = 0;
    chk("R6 flag cleared", {15'd0, flag_o}, 16'h0);
    wr16(16'hFFFF);
    tick_en = 1; flag_clr = 1; cyc(1);
    tick_en = 0; flag_clr = 0;
    chk("R6 set wins over clear", {15'd0, flag_o}, 16'h1);

    // R7 qualification sweep
    for (int k = 0; k < 8; k++) begin
      {ie_glb, ie_per, ie_tmr} = 3'(k);
      #1;
      chk($sformatf("R7 ie=%0d", k), {15'd0, irq_o}, {15'd0, (k == 7)});
      cyc(1);
    end
    flag_clr = 1; cyc(1); flag_clr = 0;
    ie_tmr = 1; ie_per = 1; ie_glb = 1; #1;
    chk("R7 no flag no irq", {15'd0, irq_o}, 16'h0);
    cyc(1);

    // R8 gate
    ctl = RUN | GATE; gate_in = 0; wr16(16'h0);
    ticks(10);
    chk("R8 gated off", cnt_o, 16'd0);
    gate_in = 1; ticks(10);
    chk("R8 gate open", cnt_o, 16'd10);
    ctl = RUN; gate_in = 0; ticks(5);
    chk("R8 gate disabled", cnt_o, 16'd15);

    // R9 hold while off, prescaler kept
    ctl = RUN | 8'h10; wr16(16'h0);
    ticks(1);
    chk("R9 half prescale", cnt_o, 16'd0);
    ctl = 8'h10; ticks(6);
    chk("R9 hold while off", cnt_o, 16'd0);
    ctl = RUN | 8'h10; ticks(1);
    chk("R9 prescaler held", cnt_o, 16'd1);

    // R12 and R11: unsynchronised, input high at enable
    ctl = 0; ext_clk = 1; cyc(2); wr16(16'h0);
    ctl = RUN | EXT | NOS; cyc(4);
    chk("R12 high at enable", cnt_o, 16'd0);
    ext_clk = 0; cyc(2);
    ext_clk = 1; cyc(1);
    chk("R11 one-edge latency", cnt_o, 16'd1);
    // rise in the enabling cycle
    ctl = 0; ext_clk = 0; cyc(2); wr16(16'h0);
    ctl = RUN | EXT | NOS; ext_clk = 1; cyc(3);
    chk("R12 rise at enable", cnt_o, 16'd0);
    ext_clk = 0; cyc(2); ext_clk = 1; cyc(1);
    chk("R12 armed after low", cnt_o, 16'd1);

    // R10 synchronised counter
    ctl = 0; ext_clk = 0; cyc(4); wr16(16'h0);
    ctl = RUN | EXT; cyc(4);
    ext_clk = 1; cyc(2);
    chk("R10 not yet (2 edges)", cnt_o, 16'd0);
    cyc(1);
    chk("R10 third edge", cnt_o, 16'd1);
    for (int i = 0; i < 5; i++) pulse_ext();
    chk("R10 pulse count", cnt_o, 16'd6);
    ext_clk = 0; cyc(4);
    ticks(5);
    chk("R10 tick ignored", cnt_o, 16'd6);
    ctl = RUN | EXT | 8'h10; wr16(16'h0);
    for (int i = 0; i < 6; i++) pulse_ext();
    chk("R10 prescaled edges", cnt_o, 16'd3);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule